// File: doc/BRIEF.md
# Trigger Rate and Buffer Watermark Throttle

This block decides when a readout back end must refuse further triggers. It raises a single busy line from up to three protection terms. Two of them are sliding-window rate limits. Each one keeps the timebase stamps of the most recent triggers and reports a hazard once too many triggers fall inside its window. The limits are sized for worst-case event sizes, so buffers never need to report back over the data link. One window guards the small front-end buffers over a short span, and the other guards the large receiver buffers over a longer span.

The third term watches the occupancy word of every receiver buffer. Each buffer has a two-state hysteresis machine with states XON and XOFF. The machine moves XON to XOFF when the occupancy reaches the high mark, stays in XOFF while the occupancy lies above the low mark, and returns XOFF to XON when the occupancy falls to the low mark or below. The per-buffer XOFF flags are outputs, and their OR is the watermark term. A three-bit enable word selects which terms feed busy.

The timebase is a tick strobe, for example one pulse per millisecond. Window lengths are counted in ticks. With the default parameters, busy rises for 7 triggers within 50 ticks, or for 100 triggers within 1000 ticks.

Top module: `trig_throttle`

## Requirements
- R1: Reset empties both trigger windows, zeroes both tick counters, puts every buffer in XON and drives busy_o low.
- R2: With prot_en_i[0] set, busy_o is high while FE_LIMIT triggers are counted in the front-end window.
- R3: A trigger is stamped with the tick count at the clock edge that registers it. It stays counted while (tick count − stamp) < window length, and stops counting at the tick that makes the difference equal to the window length.
- R4: A trigger that arrives while a window already holds its limit discards the oldest stamp and keeps the newest ones, so the window stays full.
- R5: With prot_en_i[1] set, busy_o is high while RX_LIMIT triggers are counted in the receiver window of RX_WIN ticks.
- R6: Buffer i occupies occ_i[i*OCC_W +: OCC_W]. An occupancy at or above HI_MARK moves buffer i to XOFF, which shows as xoff_o[i]=1 one cycle after the occupancy is sampled.
- R7: A buffer in XOFF stays there while its occupancy is above LO_MARK, and returns to XON (xoff_o[i]=0) one cycle after its occupancy is at or below LO_MARK.
- R8: busy_o is the OR of the terms whose enable bit is set: bit 0 is the front-end window, bit 1 is the receiver window, and bit 2 is the watermark term. A disabled term has no effect on busy_o. xoff_o does not depend on the enables.
- R9: busy_o is a register. It reflects the window and XOFF state one clock edge after that state changes, so busy follows an XOFF flag by one further cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_i | input | 1 | Trigger strobe, one trigger per cycle high |
| tick_i | input | 1 | Timebase strobe, advances the tick counters |
| prot_en_i | input | 3 | Term enables: [0] front-end window, [1] receiver window, [2] watermark |
| occ_i | input | NBUF*OCC_W | Occupancy of each receiver buffer, buffer i in slice i |
| busy_o | output | 1 | Throttle request |
| xoff_o | output | NBUF | Per-buffer XOFF flag |

## Verification
The bench places ticks so that a window holds its limit for exactly one tick less than its length, and then checks that busy drops on the tick where the age equals the length. A design off by one in the age comparison would release busy one tick early or one tick late. A trigger sent into a full window is later tested at the moment its discarded predecessor would have expired. A design that dropped the new trigger, instead of the oldest one, would release busy there too early. Occupancies are stepped through the band between the marks and onto the marks themselves, which exposes a comparator that has no hysteresis or uses the wrong inclusive edge. A reset taken while busy is followed by a single trigger, which exposes stamps that survive reset.

// File: rtl/trig_throttle_pkg.sv
package trig_throttle_pkg;
    typedef enum logic {
        WM_XON  = 1'b0,
        WM_XOFF = 1'b1
    } wm_state_e;

    localparam int EN_FE  = 0;
    localparam int EN_RX  = 1;
    localparam int EN_WM  = 2;
    localparam int EN_W   = 3;
endpackage

// File: rtl/tt_rate_window.sv
module tt_rate_window #(
    parameter int LIMIT = 7,
    parameter int WIN   = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    input  logic tick,
    output logic at_limit
);
    localparam int TW = $clog2(WIN + LIMIT + 1) + 1;
    localparam int PW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam int CW = $clog2(LIMIT + 1);

    logic [TW-1:0] now_q;
    logic [TW-1:0] stamp_q [LIMIT];
    logic [PW-1:0] rd_q, wr_q;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [TW-1:0] age;
    logic          full, expire, pop;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(LIMIT - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        age      = now_q - stamp_q[rd_q];
        full     = (cnt_q == CW'(LIMIT));
        expire   = (cnt_q != '0) && (age >= TW'(WIN));
        pop      = expire || (trig && full);
        at_limit = full && !expire;
        unique case ({trig, pop})
            2'b10:   cnt_d = cnt_q + CW'(1);
            2'b01:   cnt_d = cnt_q - CW'(1);
            default: cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            now_q <= '0;
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
            for (int i = 0; i < LIMIT; i++) stamp_q[i] <= '0;
        end else begin
            if (tick) now_q <= now_q + TW'(1);
            if (trig) begin
                stamp_q[wr_q] <= now_q;
                wr_q          <= ptr_inc(wr_q);
            end
            if (pop) rd_q <= ptr_inc(rd_q);
            cnt_q <= cnt_d;
        end
    end

    // R3
    cnt_no_growth_chk: assert property (@(posedge clk) disable iff (rst)
        !trig |=> cnt_q <= $past(cnt_q));

    // R4
    full_keeps_newest_chk: assert property (@(posedge clk) disable iff (rst)
        (trig && full) |=> (cnt_q == CW'(LIMIT)));
endmodule

// File: rtl/tt_wm_cell.sv
module tt_wm_cell
    import trig_throttle_pkg::*;
#(
    parameter int OCC_W   = 10,
    parameter int HI_MARK = 768,
    parameter int LO_MARK = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OCC_W-1:0] occ,
    output logic             xoff
);
    wm_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (rst) st_q <= WM_XON;
        else     st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WM_XON:  if (occ >= OCC_W'(HI_MARK)) st_d = WM_XOFF;
            WM_XOFF: if (occ <= OCC_W'(LO_MARK)) st_d = WM_XON;
            default: st_d = WM_XON;
        endcase
    end

    assign xoff = (st_q == WM_XOFF);

    // R6
    high_mark_xoff_chk: assert property (@(posedge clk) disable iff (rst)
        (occ >= OCC_W'(HI_MARK)) |=> xoff);

    // R7
    band_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (xoff && occ > OCC_W'(LO_MARK)) |=> xoff);
endmodule

// File: rtl/trig_throttle.sv
module trig_throttle
    import trig_throttle_pkg::*;
#(
    parameter int FE_LIMIT = 7,
    parameter int FE_WIN   = 50,
    parameter int RX_LIMIT = 100,
    parameter int RX_WIN   = 1000,
    parameter int NBUF     = 4,
    parameter int OCC_W    = 10,
    parameter int HI_MARK  = 768,
    parameter int LO_MARK  = 256
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  trig_i,
    input  logic                  tick_i,
    input  logic [2:0]            prot_en_i,
    input  logic [NBUF*OCC_W-1:0] occ_i,
    output logic                  busy_o,
    output logic [NBUF-1:0]       xoff_o
);
    logic fe_term, rx_term, wm_term, busy_d;

    tt_rate_window #(.LIMIT(FE_LIMIT), .WIN(FE_WIN)) u_fe_win (
        .clk(clk), .rst(rst), .trig(trig_i), .tick(tick_i), .at_limit(fe_term)
    );

    tt_rate_window #(.LIMIT(RX_LIMIT), .WIN(RX_WIN)) u_rx_win (
        .clk(clk), .rst(rst), .trig(trig_i), .tick(tick_i), .at_limit(rx_term)
    );

    for (genvar b = 0; b < NBUF; b++) begin : g_buf
        tt_wm_cell #(.OCC_W(OCC_W), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK)) u_cell (
            .clk(clk), .rst(rst), .occ(occ_i[b*OCC_W +: OCC_W]), .xoff(xoff_o[b])
        );
    end

    assign wm_term = |xoff_o;

    always_comb begin
        busy_d = (prot_en_i[EN_FE] & fe_term)
               | (prot_en_i[EN_RX] & rx_term)
               | (prot_en_i[EN_WM] & wm_term);
    end

    always_ff @(posedge clk) begin
        if (rst) busy_o <= 1'b0;
        else     busy_o <= busy_d;
    end

    // R8
    all_disabled_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (prot_en_i == 3'b000) |=> !busy_o);
endmodule

// File: tb/sim_trig_throttle.sv
module sim_trig_throttle;
    localparam int NB = 2;
    localparam int OW = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic trig_i = 1'b0, tick_i = 1'b0;
    logic [2:0] prot_en_i = 3'b001;
    logic [NB*OW-1:0] occ_i = '0;
    logic busy_o;
    logic [NB-1:0] xoff_o;

    always #2 clk = ~clk;

    trig_throttle #(
        .FE_LIMIT(3), .FE_WIN(8), .RX_LIMIT(5), .RX_WIN(20),
        .NBUF(NB), .OCC_W(OW), .HI_MARK(40), .LO_MARK(10)
    ) u0 (
        .clk(clk), .rst(rst), .trig_i(trig_i), .tick_i(tick_i),
        .prot_en_i(prot_en_i), .occ_i(occ_i), .busy_o(busy_o), .xoff_o(xoff_o)
    );

    int n_vec = 0, n_bad = 0;
    bit done = 0;
    logic          exp_busy_q[$];
    logic [NB-1:0] exp_xoff_q[$];
    string         exp_tag_q[$];
    event          sample_ev;

    // monitor: pops each expected item and compares it with the outputs
    initial forever begin
        @(sample_ev);
        while (exp_tag_q.size() > 0) begin
            logic eb;
            logic [NB-1:0] ex;
            string t;
            eb = exp_busy_q.pop_front();
            ex = exp_xoff_q.pop_front();
            t  = exp_tag_q.pop_front();
            n_vec++;
            if (busy_o !== eb || xoff_o !== ex) begin
                n_bad++;
                $display("FAIL %s: busy=%b xoff=%b expected busy=%b xoff=%b",
                         t, busy_o, xoff_o, eb, ex);
            end
        end
    end

    task automatic cyc(input logic t, input logic k);
        trig_i = t; tick_i = k;
        @(negedge clk);
        trig_i = 1'b0; tick_i = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b1);
    endtask

    task automatic chk(input logic b, input logic [NB-1:0] x, input string tag);
        exp_busy_q.push_back(b);
        exp_xoff_q.push_back(x);
        exp_tag_q.push_back(tag);
        -> sample_ev;
        #0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL R9 watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(1'b0, 2'b00, "R1 reset state");

        // front-end window, limit 3 in 8 ticks
        cyc(1, 0); cyc(1, 0); idle(1);
        chk(1'b0, 2'b00, "R2 two triggers below limit");
        cyc(1, 0); idle(1);
        chk(1'b1, 2'b00, "R2 limit reached");
        ticks(7); idle(1);
        chk(1'b1, 2'b00, "R3 age 7 still counted");
        ticks(1); idle(1);
        chk(1'b0, 2'b00, "R3 age 8 expired");
        idle(4);
        cyc(1, 0); ticks(3); cyc(1, 0); cyc(1, 0); idle(1);
        chk(1'b1, 2'b00, "R2 spread triggers");
        cyc(1, 0); idle(1);
        chk(1'b1, 2'b00, "R4 trigger into full window");
        ticks(5); idle(1);
        chk(1'b1, 2'b00, "R4 oldest discarded, newest kept");
        ticks(3); idle(1);
        chk(1'b0, 2'b00, "R3 newest expired");

        // enables
        idle(4);
        cyc(1, 0); cyc(1, 0); cyc(1, 0); idle(1);
        chk(1'b1, 2'b00, "R2 refill");
        prot_en_i = 3'b000; idle(1);
        chk(1'b0, 2'b00, "R8 front-end term disabled");
        prot_en_i = 3'b001; idle(1);
        chk(1'b1, 2'b00, "R8 front-end term re-enabled");

        // receiver window, limit 5 in 20 ticks
        prot_en_i = 3'b010;
        ticks(25); idle(6);
        cyc(1, 0); cyc(1, 0); cyc(1, 0); cyc(1, 0); idle(1);
        chk(1'b0, 2'b00, "R5 four triggers below limit");
        cyc(1, 0); idle(1);
        chk(1'b1, 2'b00, "R5 limit reached");
        ticks(19); idle(1);
        chk(1'b1, 2'b00, "R5 age 19 still counted");
        ticks(1); idle(1);
        chk(1'b0, 2'b00, "R3 receiver window expired");

        // watermarks, high 40 low 10
        prot_en_i = 3'b100;
        occ_i[0 +: OW] = 6'd39; idle(2);
        chk(1'b0, 2'b00, "R6 below high mark");
        occ_i[0 +: OW] = 6'd40; idle(1);
        chk(1'b0, 2'b01, "R9 xoff before busy");
        idle(1);
        chk(1'b1, 2'b01, "R6 high mark busy");
        occ_i[0 +: OW] = 6'd20; idle(2);
        chk(1'b1, 2'b01, "R7 hold in band");
        occ_i[0 +: OW] = 6'd11; idle(2);
        chk(1'b1, 2'b01, "R7 hold one above low");
        occ_i[0 +: OW] = 6'd10; idle(1);
        chk(1'b1, 2'b00, "R7 release at low mark");
        idle(1);
        chk(1'b0, 2'b00, "R9 busy follows release");
        occ_i[0 +: OW] = 6'd45; occ_i[OW +: OW] = 6'd63; idle(2);
        chk(1'b1, 2'b11, "R6 both buffers xoff");
        occ_i[0 +: OW] = 6'd0; idle(2);
        chk(1'b1, 2'b10, "R7 buffer 1 still xoff");
        prot_en_i = 3'b000; idle(1);
        chk(1'b0, 2'b10, "R8 watermark disabled, flags kept");

        // reset while busy
        prot_en_i = 3'b001;
        idle(10);
        cyc(1, 0); cyc(1, 0); cyc(1, 0); idle(1);
        chk(1'b1, 2'b10, "R2 busy before reset");
        occ_i = '0;
        rst = 1'b1; idle(1); rst = 1'b0;
        chk(1'b0, 2'b00, "R1 reset while busy");
        cyc(1, 0); idle(1);
        chk(1'b0, 2'b00, "R1 window emptied by reset");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule